// File: doc/BRIEF.md
# Indexed-Address Opcode Fetch Sequencer

This block is the T-state sequencer at the front of an 8-bit CPU whose instructions may carry an index-register prefix. It runs the opcode fetch machine cycle: address out, a read that can be stretched by wait, then a refresh state. After that it hands the opcode and an effective memory address to the execute stage. Without a prefix the address comes from HL. With a prefix it comes from IX or IY, as the prefix select input says.

A prefixed opcode that addresses memory through the pointer register gets an extra eight-state machine cycle. This cycle reads a signed displacement byte at the program counter and adds it to the index value. The store-immediate opcode (0x36) also reads its immediate byte during that cycle. It then runs a two-state write cycle that stores the byte at the computed address before dispatch.

Dispatch is a valid/ready stream. `dsp_valid` rises when a fetch completes and stays high, with the whole payload frozen, until `dsp_ready` is seen high at a clock edge. The sequencer starts the next fetch only after that acceptance, so back-pressure stalls the whole fetch front end. The execute stage accepts and starts its work in that same edge. With `dsp_ready` tied high the valid is a single-cycle pulse. Prefix state (`pfx_en`, `pfx_sel`) is sampled in the first fetch state. HL, IX and IY are sampled in the fourth.

Top module: `idxf_seq`

## Requirements
- R1: While reset is asserted and after its release, `pc` is 0 and `dsp_valid` is 0. The first refresh after reset presents counter value 0.
- R2: A fetch reads at `pc` with `m1` and `rd` high. The opcode is taken from `din` in the cycle where `wait_i` is low, and `pc` then increments. For an unprefixed opcode, dispatch carries that opcode, `dsp_ea` = HL and `dsp_prefixed` = 0. `dsp_valid` shows five clock edges after the previous acceptance.
- R3: The state after the opcode read drives `rfsh` for one cycle. In that state `addr[6:0]` shows a 7-bit refresh counter and the upper address bits are 0. The counter grows by one per fetch and wraps.
- R4: A prefixed fetch with `pfx_sel` = 0 uses IX and with `pfx_sel` = 1 uses IY. Its dispatch has `dsp_prefixed` = 1. A prefixed opcode outside the R5 set dispatches with `dsp_ea` = the index value, after five edges, with no extra bus read.
- R5: A prefixed opcode needs a displacement when it is one of these: 0x34, 0x35, 0x36; any 01xxx110 or 01110xxx except 0x76; any 10xxx110.
- R6: For an R5 opcode, the byte at the next `pc` is read and `pc` increments. `dsp_ea` and `dsp_wz` both equal the index value plus the sign-extended byte, modulo 2^16. Dispatch comes 13 edges after acceptance.
- R7: For prefixed 0x36, a third byte is read at the next `pc` and written once with `wr` to `dsp_ea`. Dispatch comes 15 edges after acceptance. No other opcode writes.
- R8: `wait_i` high during a read or write holds that access. Address and strobes stay unchanged and each wait cycle adds exactly one cycle.
- R9: While `dsp_valid` is high and `dsp_ready` is low, the payload is held stable and no new fetch begins.
- R10: At most one of `rd`, `wr`, `rfsh` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_i | input | 1 | Stretches the current bus access while high |
| din | input | 8 | Read data bus |
| pfx_en | input | 1 | Index prefix active for this fetch |
| pfx_sel | input | 1 | 0 selects IX, 1 selects IY |
| hl | input | 16 | HL register value |
| ix | input | 16 | IX register value |
| iy | input | 16 | IY register value |
| dsp_ready | input | 1 | Execute stage accepts dispatch |
| addr | output | 16 | Address bus |
| dout | output | 8 | Write data bus |
| rd | output | 1 | Memory read strobe |
| wr | output | 1 | Memory write strobe |
| m1 | output | 1 | Opcode fetch indicator |
| rfsh | output | 1 | Refresh strobe |
| pc | output | 16 | Program counter |
| dsp_valid | output | 1 | Dispatch payload valid |
| dsp_opcode | output | 8 | Dispatched opcode |
| dsp_ea | output | 16 | Effective address |
| dsp_wz | output | 16 | Temporary copy of the indexed address |
| dsp_prefixed | output | 1 | Prefix was active for this opcode |

## Verification
A wrong state transition changes the count of edges between two dispatches. Each transaction is timed, so it shows within one instruction. An error in the indexed-opcode set or in the store special case appears as a wrong `pc` advance, a missing or extra write, or a wrong effective address at the next dispatch. Refresh-counter faults appear in the very next refresh state. A stall or back-pressure fault appears as a moved address or a changed payload in the cycle that follows.

// File: rtl/idxf_pkg.sv
package idxf_pkg;

  localparam logic [7:0] STORE_IMM_OP = 8'h36;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_F4,
    S_D1, S_D2, S_D3, S_D4, S_D5, S_D6, S_D7, S_D8,
    S_W1, S_W2, S_DSP
  } st_t;

  // Opcodes whose pointer operand becomes (index + displacement) under a prefix
  function automatic logic needs_disp(input logic [7:0] op);
    logic [1:0] grp;
    logic [2:0] dst;
    logic [2:0] src;
    logic       hit;
    grp = op[7:6];
    dst = op[5:3];
    src = op[2:0];
    hit = 1'b0;
    if (op == 8'h76) begin
      hit = 1'b0;
    end else if (grp == 2'b01) begin
      hit = (src == 3'b110) || (dst == 3'b110);
    end else if (grp == 2'b10) begin
      hit = (src == 3'b110);
    end else if (grp == 2'b00) begin
      hit = (dst == 3'b110) && (src == 3'b100 || src == 3'b101 || src == 3'b110);
    end
    return hit;
  endfunction

  function automatic logic is_access_state(input st_t s, input logic store_op);
    logic r;
    case (s)
      S_F2, S_D2, S_W2: r = 1'b1;
      S_D5:             r = store_op;
      default:          r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/idxf_ctrl.sv
module idxf_ctrl
  import idxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_i,
  input  logic       pfx_q,
  input  logic [7:0] op_q,
  input  logic       dsp_ready,
  output st_t        st
);

  st_t  nxt;
  logic store_op;
  logic stall;

  assign store_op = (op_q == STORE_IMM_OP);
  assign stall    = wait_i && is_access_state(st, store_op);

  always_comb begin
    nxt = st;
    if (!stall) begin
      case (st)
        S_F1: nxt = S_F2;
        S_F2: nxt = S_F3;
        S_F3: nxt = S_F4;
        S_F4: nxt = (pfx_q && needs_disp(op_q)) ? S_D1 : S_DSP;
        S_D1: nxt = S_D2;
        S_D2: nxt = S_D3;
        S_D3: nxt = S_D4;
        S_D4: nxt = S_D5;
        S_D5: nxt = S_D6;
        S_D6: nxt = S_D7;
        S_D7: nxt = S_D8;
        S_D8: nxt = store_op ? S_W1 : S_DSP;
        S_W1: nxt = S_W2;
        S_W2: nxt = S_DSP;
        S_DSP: nxt = dsp_ready ? S_F1 : S_DSP;
        default: nxt = S_F1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_F1;
    else        st <= nxt;
  end

endmodule

// File: rtl/idxf_dpath.sv
module idxf_dpath
  import idxf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RC_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_t               st,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] din,
  input  logic              pfx_en,
  input  logic              pfx_sel,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] iy,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] op_q,
  output logic              pfx_q,
  output logic [DATA_W-1:0] imm_q,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] wz,
  output logic [RC_W-1:0]   rcnt
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic              sel_q;
  logic [DATA_W-1:0] disp_q;
  logic              store_op;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] idx_val;
  logic [ADDR_W-1:0] ea_sum;
  logic              take_byte;

  assign store_op  = (op_q == STORE_IMM_OP);
  assign disp_ext  = {{EXT_W{disp_q[DATA_W-1]}}, disp_q};
  assign idx_val   = sel_q ? iy : ix;
  assign ea_sum    = ea + disp_ext;
  assign take_byte = !wait_i && is_access_state(st, store_op) && (st != S_W2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      op_q   <= '0;
      pfx_q  <= 1'b0;
      sel_q  <= 1'b0;
      disp_q <= '0;
      imm_q  <= '0;
      ea     <= '0;
      wz     <= '0;
      rcnt   <= '0;
    end else begin
      if (take_byte) pc <= pc + 1'b1;
      case (st)
        S_F1: begin
          pfx_q <= pfx_en;
          sel_q <= pfx_sel;
        end
        S_F2: if (!wait_i) op_q <= din;
        S_F3: rcnt <= rcnt + 1'b1;
        S_F4: ea <= pfx_q ? idx_val : hl;
        S_D2: if (!wait_i) disp_q <= din;
        S_D3: begin
          ea <= ea_sum;
          wz <= ea_sum;
        end
        S_D5: if (store_op && !wait_i) imm_q <= din;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/idxf_busdrv.sv
module idxf_busdrv
  import idxf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RC_W   = 7
) (
  input  st_t               st,
  input  logic [DATA_W-1:0] op_q,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] imm_q,
  input  logic [RC_W-1:0]   rcnt,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              rd,
  output logic              wr,
  output logic              m1,
  output logic              rfsh
);

  localparam int PAD_W = ADDR_W - RC_W;

  logic store_op;
  assign store_op = (op_q == STORE_IMM_OP);

  always_comb begin
    addr = '0;
    dout = '0;
    rd   = 1'b0;
    wr   = 1'b0;
    m1   = 1'b0;
    rfsh = 1'b0;
    case (st)
      S_F1: begin
        addr = pc;
        m1   = 1'b1;
      end
      S_F2: begin
        addr = pc;
        m1   = 1'b1;
        rd   = 1'b1;
      end
      S_F3: begin
        addr = {{PAD_W{1'b0}}, rcnt};
        rfsh = 1'b1;
      end
      S_D2: begin
        addr = pc;
        rd   = 1'b1;
      end
      S_D5: begin
        if (store_op) begin
          addr = pc;
          rd   = 1'b1;
        end
      end
      S_W1: begin
        addr = ea;
        dout = imm_q;
      end
      S_W2: begin
        addr = ea;
        dout = imm_q;
        wr   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/idxf_seq.sv
module idxf_seq
  import idxf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RC_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] din,
  input  logic              pfx_en,
  input  logic              pfx_sel,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] iy,
  input  logic              dsp_ready,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              rd,
  output logic              wr,
  output logic              m1,
  output logic              rfsh,
  output logic [ADDR_W-1:0] pc,
  output logic              dsp_valid,
  output logic [DATA_W-1:0] dsp_opcode,
  output logic [ADDR_W-1:0] dsp_ea,
  output logic [ADDR_W-1:0] dsp_wz,
  output logic              dsp_prefixed
);

  st_t               st;
  logic [DATA_W-1:0] op_q;
  logic              pfx_q;
  logic [DATA_W-1:0] imm_q;
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] wz;
  logic [RC_W-1:0]   rcnt;

  idxf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_i    (wait_i),
    .pfx_q     (pfx_q),
    .op_q      (op_q),
    .dsp_ready (dsp_ready),
    .st        (st)
  );

  idxf_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RC_W(RC_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .wait_i  (wait_i),
    .din     (din),
    .pfx_en  (pfx_en),
    .pfx_sel (pfx_sel),
    .hl      (hl),
    .ix      (ix),
    .iy      (iy),
    .pc      (pc),
    .op_q    (op_q),
    .pfx_q   (pfx_q),
    .imm_q   (imm_q),
    .ea      (ea),
    .wz      (wz),
    .rcnt    (rcnt)
  );

  idxf_busdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RC_W(RC_W)) u_bus (
    .st    (st),
    .op_q  (op_q),
    .pc    (pc),
    .ea    (ea),
    .imm_q (imm_q),
    .rcnt  (rcnt),
    .addr  (addr),
    .dout  (dout),
    .rd    (rd),
    .wr    (wr),
    .m1    (m1),
    .rfsh  (rfsh)
  );

  assign dsp_valid    = (st == S_DSP);
  assign dsp_opcode   = op_q;
  assign dsp_ea       = ea;
  assign dsp_wz       = wz;
  assign dsp_prefixed = pfx_q;

endmodule

// File: rtl/idxf_seq_chk.sv
module idxf_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RC_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wait_i,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              rd,
  input logic              wr,
  input logic              m1,
  input logic              rfsh,
  input logic [ADDR_W-1:0] pc,
  input logic              dsp_valid,
  input logic              dsp_ready,
  input logic [DATA_W-1:0] dsp_opcode,
  input logic [ADDR_W-1:0] dsp_ea
);

  logic [RC_W-1:0] last_rc;
  logic            rc_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rc <= '0;
      rc_seen <= 1'b0;
    end else if (rfsh) begin
      last_rc <= addr[RC_W-1:0];
      rc_seen <= 1'b1;
    end
  end

  // R10: strobes are mutually exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd, wr, rfsh}));

  // R3: refresh counter steps by one between refresh states
  p_rfsh_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh && rc_seen) |-> (addr[RC_W-1:0] == RC_W'(last_rc + 1'b1)));

  // R1: first refresh after reset shows zero
  p_rfsh_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh && !rc_seen) |-> (addr == '0));

  // R8: a stalled read keeps its address and strobe
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wait_i) |=> (rd && $stable(addr)));

  // R8: a stalled write keeps address and data
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wait_i) |=> (wr && $stable(addr) && $stable(dout)));

  // R2: completed opcode read advances pc and is followed by refresh
  p_fetch_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 && rd && !wait_i) |=> (rfsh && pc == ADDR_W'($past(pc) + 1'b1)));

  // R9: held dispatch keeps its payload
  p_dsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_opcode) && $stable(dsp_ea)));

endmodule

bind idxf_seq idxf_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RC_W(RC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wait_i     (wait_i),
  .addr       (addr),
  .dout       (dout),
  .rd         (rd),
  .wr         (wr),
  .m1         (m1),
  .rfsh       (rfsh),
  .pc         (pc),
  .dsp_valid  (dsp_valid),
  .dsp_ready  (dsp_ready),
  .dsp_opcode (dsp_opcode),
  .dsp_ea     (dsp_ea)
);

// File: tb/sim_idxf_seq.sv
`timescale 1ns/1ps
module sim_idxf_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wait_i = 1'b0;
  logic [7:0]  din;
  logic        pfx_en = 1'b0;
  logic        pfx_sel = 1'b0;
  logic [15:0] hl = '0, ix = '0, iy = '0;
  logic        dsp_ready = 1'b1;
  logic [15:0] addr, pc, dsp_ea, dsp_wz;
  logic [7:0]  dout, dsp_opcode;
  logic        rd, wr, m1, rfsh, dsp_valid, dsp_prefixed;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [15:0] base = '0;
  logic [7:0]  b_op = '0, b_d = '0, b_imm = '0;
  int          wstall = 0;
  int          scnt = 0;
  int          nwr = 0;
  logic [15:0] wr_a = '0;
  logic [7:0]  wr_d = '0;
  logic        wr_prev = 1'b0;
  logic [6:0]  rc_exp = '0;
  logic [15:0] exp_pc = '0;

  always #2.5 clk = ~clk;

  idxf_seq u0 (
    .clk(clk), .rst_n(rst_n), .wait_i(wait_i), .din(din),
    .pfx_en(pfx_en), .pfx_sel(pfx_sel), .hl(hl), .ix(ix), .iy(iy),
    .dsp_ready(dsp_ready), .addr(addr), .dout(dout), .rd(rd), .wr(wr),
    .m1(m1), .rfsh(rfsh), .pc(pc), .dsp_valid(dsp_valid),
    .dsp_opcode(dsp_opcode), .dsp_ea(dsp_ea), .dsp_wz(dsp_wz),
    .dsp_prefixed(dsp_prefixed)
  );

  always_comb begin
    if (addr == base)                din = b_op;
    else if (addr == base + 16'd1)   din = b_d;
    else if (addr == base + 16'd2)   din = b_imm;
    else                             din = 8'hFF;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // wait generator: stretches every access by wstall cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      wait_i <= 1'b0;
      scnt   <= 0;
    end else if ((rd || wr) && scnt < wstall) begin
      wait_i <= 1'b1;
      scnt   <= scnt + 1;
    end else begin
      wait_i <= 1'b0;
      if (!(rd || wr)) scnt <= 0;
    end
  end

  // refresh and write monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (rfsh) begin
        chk(addr == {9'd0, rc_exp}, "R3 refresh address", addr, {9'd0, rc_exp});
        rc_exp = rc_exp + 7'd1;
      end
      if (wr && !wr_prev) begin
        nwr++;
        wr_a = addr;
        wr_d = dout;
      end
      wr_prev = wr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic ref_flag(input logic [7:0] op);
    logic a, b, c, d;
    a = ((op & 8'hC7) == 8'h46) && (op != 8'h76);
    b = ((op & 8'hF8) == 8'h70) && (op != 8'h76);
    c = ((op & 8'hC7) == 8'h86);
    d = (op == 8'h34) || (op == 8'h35) || (op == 8'h36);
    return a || b || c || d;
  endfunction

  task automatic run_txn(input logic pe, input logic sel, input logic [7:0] op,
                         input logic [7:0] d, input logic [7:0] imm,
                         input logic [15:0] vhl, input logic [15:0] vix, input logic [15:0] viy,
                         input int w, input int hold, input logic timed);
    int          cnt;
    logic        fl, st;
    int          exp_cyc;
    logic [15:0] idx, exp_ea;
    logic [15:0] pc0;
    pfx_en = pe; pfx_sel = sel; hl = vhl; ix = vix; iy = viy;
    b_op = op; b_d = d; b_imm = imm; base = exp_pc; wstall = w;
    nwr = 0;
    pc0 = exp_pc;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!dsp_valid && cnt < 200);
    fl = pe && ref_flag(op);
    st = fl && (op == 8'h36);
    exp_cyc = 5 + (fl ? 8 : 0) + (st ? 2 : 0) + w * (1 + (fl ? 1 : 0) + (st ? 2 : 0));
    idx = sel ? viy : vix;
    exp_ea = !pe ? vhl : (fl ? idx + {{8{d[7]}}, d} : idx);
    exp_pc = pc0 + 16'(1 + (fl ? 1 : 0) + (st ? 1 : 0));
    chk(dsp_valid, "R2 dispatch valid", dsp_valid, 1);
    chk(dsp_opcode == op, "R2 opcode", dsp_opcode, op);
    chk(dsp_prefixed == pe, "R4 prefixed flag", dsp_prefixed, pe);
    if (!pe) chk(dsp_ea == exp_ea, "R2 ea from HL", dsp_ea, exp_ea);
    else if (!fl) chk(dsp_ea == exp_ea, "R4 ea from index", dsp_ea, exp_ea);
    else begin
      chk(dsp_ea == exp_ea, "R6 ea displaced", dsp_ea, exp_ea);
      chk(dsp_wz == exp_ea, "R6 wz copy", dsp_wz, exp_ea);
    end
    chk(pc == exp_pc, fl ? "R5 pc advance" : "R2 pc advance", pc, exp_pc);
    if (timed) begin
      if (w > 0) chk(cnt == exp_cyc, "R8 stretched cycles", cnt, exp_cyc);
      else if (st) chk(cnt == exp_cyc, "R7 store cycles", cnt, exp_cyc);
      else if (fl) chk(cnt == exp_cyc, "R6 indexed cycles", cnt, exp_cyc);
      else chk(cnt == exp_cyc, "R2 fetch cycles", cnt, exp_cyc);
    end
    if (st) begin
      chk(nwr == 1, "R7 write count", nwr, 1);
      chk(wr_a == exp_ea, "R7 write address", wr_a, exp_ea);
      chk(wr_d == imm, "R7 write data", wr_d, imm);
    end else begin
      chk(nwr == 0, "R7 no write", nwr, 0);
    end
    if (hold > 0) begin
      dsp_ready = 1'b0;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(dsp_valid && dsp_opcode == op && dsp_ea == exp_ea && pc == exp_pc && !rd,
            "R9 held dispatch", {dsp_valid, dsp_opcode}, {1'b1, op});
      end
      dsp_ready = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pc == 16'd0, "R1 reset pc", pc, 0);
    chk(!dsp_valid, "R1 reset valid", dsp_valid, 0);
    chk(!rd && !wr && !rfsh, "R1 reset strobes", {rd, wr, rfsh}, 0);
    rst_n = 1'b1;
    chk(pc == 16'd0, "R1 pc after release", pc, 0);
    run_txn(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h0, 16'h0, 0, 0, 1'b0);
    // R2: every opcode unprefixed
    for (int op = 0; op < 256; op++)
      run_txn(1'b0, 1'b0, 8'(op), 8'h80, 8'h11, 16'h1000 + 16'(op * 37), 16'hAAAA, 16'h5555, 0, 0, 1'b1);
    // R4, R5, R6, R7: every opcode under IX with varying displacement and wrap
    for (int op = 0; op < 256; op++)
      run_txn(1'b1, 1'b0, 8'(op), 8'(op * 7 + 3), 8'(op ^ 8'hA5),
              16'h2222, (op[0] ? 16'hFFF0 : 16'h0005) + 16'(op), 16'h7777, 0, 0, 1'b1);
    // same under IY
    for (int op = 0; op < 256; op++)
      run_txn(1'b1, 1'b1, 8'(op), 8'(255 - op), 8'(op + 1),
              16'h3333, 16'h4444, 16'h8000 + 16'(op * 11), 0, 0, 1'b1);
    // R8: wait states on all access kinds
    for (int w = 1; w <= 3; w++) begin
      run_txn(1'b0, 1'b0, 8'h7E, 8'h00, 8'h00, 16'h0F0F, 16'h0, 16'h0, w, 0, 1'b1);
      run_txn(1'b1, 1'b0, 8'h86, 8'hFE, 8'h00, 16'h0, 16'h1000, 16'h0, w, 0, 1'b1);
      run_txn(1'b1, 1'b1, 8'h36, 8'h7F, 8'h5C, 16'h0, 16'h0, 16'hFFC0, w, 0, 1'b1);
    end
    // R9: back-pressure on dispatch
    run_txn(1'b0, 1'b0, 8'h01, 8'h00, 8'h00, 16'h4321, 16'h0, 16'h0, 0, 4, 1'b1);
    run_txn(1'b1, 1'b0, 8'h36, 8'h80, 8'h99, 16'h0, 16'h0100, 16'h0, 0, 3, 1'b1);
    run_txn(1'b1, 1'b1, 8'h46, 8'h10, 8'h00, 16'h0, 16'h0, 16'h2000, 1, 2, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule